// File: doc/BRIEF.md
# Dual-Direction Modular Butterfly for a 256-Point NTT

This block is the arithmetic heart of a 256-point number-theoretic transform over the prime field of modulus 3329. It takes two 12-bit coefficients, a 12-bit twiddle factor and a direction bit. It returns two coefficients that are fully reduced. The block has no clock and no storage. Its outputs follow the inputs in the same cycle, so a surrounding sequencer can register them wherever its timing allows.

With the direction bit low, the block computes a decimation-in-time (Cooley-Tukey) butterfly for the forward transform. The twiddle multiplies the second coefficient, and that product is then added to and subtracted from the first. With the direction bit high, it computes a decimation-in-frequency (Gentleman-Sande) butterfly for the inverse transform. The two coefficients are summed, and their difference is multiplied by the twiddle. A Barrett-style reduction forms every product, so no divider is needed.

The twiddle schedule, coefficient storage, layer sequencing and the final scaling by 3303 (the inverse of 128) after an inverse transform all belong to the surrounding engine.

Top module: `modq_butterfly`

## Requirements
- R1: For inputs in the range 0 to 3328, both outputs always lie in the range 0 to 3328.
- R2: With `dir_i` = 0 (forward), `x_o` equals (x + w·y) mod 3329.
- R3: With `dir_i` = 0 (forward), `y_o` equals (x − w·y) mod 3329, taken as a non-negative residue.
- R4: With `dir_i` = 1 (inverse), `x_o` equals (x + y) mod 3329.
- R5: With `dir_i` = 1 (inverse), `y_o` equals w·(y − x) mod 3329.
- R6: A sum that reaches 3329 or more wraps by subtracting 3329. For example, inverse mode with x = 3328 and y = 1 gives `x_o` = 0.
- R7: A negative difference is corrected by adding 3329. For example, inverse mode with x = 1, y = 0 and w = 1 gives `y_o` = 3328.
- R8: A twiddle of 1 reduces the forward butterfly to a plain modular sum and difference of x and y.
- R9: The outputs are a function of the current inputs only. They take their new values within the same cycle the inputs change, with no clock edge in between.
- R10: All-zero coefficients give all-zero outputs in both modes, whatever the twiddle.
- R11: The modular product is exact at the top of the range: w = y = 3328 yields a product of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | 12 | First coefficient (residue 0..3328) |
| y_i | input | 12 | Second coefficient (residue 0..3328) |
| w_i | input | 12 | Twiddle factor (residue 0..3328) |
| dir_i | input | 1 | 0 = forward (Cooley-Tukey), 1 = inverse (Gentleman-Sande) |
| x_o | output | 12 | Upper butterfly output |
| y_o | output | 12 | Lower butterfly output |

## Verification
In forward mode the modular adder can wrap in the same evaluation in which the modular subtractor borrows. Both then act on the same twiddle product. The bench forces this with x = 1, y = 3328 and w = 1, where the sum must wrap to 0 and the difference must borrow to 2. It judges both outputs in the same sample against an integer model. In inverse mode, the borrow of the difference feeding the multiplier can coincide with the multiplier's final Barrett correction. Random vectors cover this case, and every result is checked against plain `%` arithmetic.

// File: rtl/modq_bf_pkg.sv
package modq_bf_pkg;

    localparam int unsigned COEF_W  = 12;
    localparam int unsigned MODULUS = 3329;

    typedef enum logic {
        BF_FWD = 1'b0,
        BF_INV = 1'b1
    } bf_dir_e;

    // floor(2^shift / q), used as the Barrett reciprocal
    function automatic int unsigned barrett_factor(int unsigned shift, int unsigned q);
        longint unsigned num;
        num = 64'd1 << shift;
        return int'(num / longint'(q));
    endfunction

endpackage

// File: rtl/modq_add.sv
module modq_add
    import modq_bf_pkg::*;
#(
    parameter int unsigned W = COEF_W,
    parameter int unsigned Q = MODULUS
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic [W-1:0] s_o
);
    localparam logic [W:0] QX = (W+1)'(Q);

    logic [W:0] raw;
    logic [W:0] less_q;

    always_comb begin
        raw    = {1'b0, x_i} + {1'b0, y_i};
        less_q = raw - QX;
        s_o    = (raw >= QX) ? less_q[W-1:0] : raw[W-1:0];
    end

    // R6: a wrapped sum is still a canonical residue
    always_comb begin
        if (!$isunknown({x_i, y_i}) && ({1'b0, x_i} < QX) && ({1'b0, y_i} < QX)) begin
            a_r6_sum_canonical: assert ({1'b0, s_o} < QX)
                else $error("modq_add result out of range");
        end
    end

endmodule

// File: rtl/modq_sub.sv
module modq_sub
    import modq_bf_pkg::*;
#(
    parameter int unsigned W = COEF_W,
    parameter int unsigned Q = MODULUS
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic [W-1:0] d_o
);
    localparam logic [W:0]   QX = (W+1)'(Q);
    localparam logic [W-1:0] QL = W'(Q);

    logic [W:0] raw;
    logic       borrow;

    always_comb begin
        raw    = {1'b0, x_i} - {1'b0, y_i};
        borrow = raw[W];
        d_o    = borrow ? (raw[W-1:0] + QL) : raw[W-1:0];
    end

    // R7: result is canonical and adding back the subtrahend restores x
    always_comb begin
        if (!$isunknown({x_i, y_i}) && ({1'b0, x_i} < QX) && ({1'b0, y_i} < QX)) begin
            a_r7_diff_canonical: assert ({1'b0, d_o} < QX)
                else $error("modq_sub result out of range");
            a_r7_diff_inverse: assert ((({2'b0, d_o} + {2'b0, y_i}) == {2'b0, x_i}) ||
                                       (({2'b0, d_o} + {2'b0, y_i}) == ({2'b0, x_i} + {1'b0, QX})))
                else $error("modq_sub does not invert");
        end
    end

endmodule

// File: rtl/modq_mul.sv
module modq_mul
    import modq_bf_pkg::*;
#(
    parameter int unsigned W = COEF_W,
    parameter int unsigned Q = MODULUS
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic [W-1:0] p_o
);
    localparam int unsigned PW = 2 * W;
    localparam int unsigned SH = 2 * W;
    localparam int unsigned TW = SH + W + 2;
    localparam int unsigned M  = barrett_factor(SH, Q);

    localparam logic [TW-1:0] MT  = TW'(M);
    localparam logic [PW-1:0] QP  = PW'(Q);
    localparam logic [W:0]    QX  = (W+1)'(Q);
    localparam logic [PW-1:0] Q2P = PW'(2 * Q);

    logic [PW-1:0] prod;
    logic [TW-1:0] est;
    logic [W:0]    qhat;
    logic [PW-1:0] rem_full;
    logic [W:0]    rem;
    logic [W:0]    rem_less_q;

    always_comb begin
        prod       = {{W{1'b0}}, x_i} * {{W{1'b0}}, y_i};
        est        = {{(TW-PW){1'b0}}, prod} * MT;
        qhat       = est[SH +: W+1];
        rem_full   = prod - ({{(PW-W-1){1'b0}}, qhat} * QP);
        rem        = rem_full[W:0];
        rem_less_q = rem - QX;
        p_o        = (rem >= QX) ? rem_less_q[W-1:0] : rem[W-1:0];
    end

    // R11: the quotient estimate is off by at most one, so one correction suffices
    always_comb begin
        if (!$isunknown({x_i, y_i}) && ({1'b0, x_i} < QX) && ({1'b0, y_i} < QX)) begin
            a_r11_barrett_bound: assert (rem_full < Q2P)
                else $error("Barrett remainder exceeds 2q");
            a_r11_prod_canonical: assert ({1'b0, p_o} < QX)
                else $error("modq_mul result out of range");
        end
    end

endmodule

// File: rtl/modq_butterfly.sv
module modq_butterfly
    import modq_bf_pkg::*;
#(
    parameter int unsigned W = COEF_W,
    parameter int unsigned Q = MODULUS
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic [W-1:0] w_i,
    input  logic         dir_i,
    output logic [W-1:0] x_o,
    output logic [W-1:0] y_o
);
    localparam logic [W:0] QX = (W+1)'(Q);

    bf_dir_e     dir;
    logic [W-1:0] diff_inv;   // y - x, used only in inverse mode
    logic [W-1:0] mul_rhs;
    logic [W-1:0] prod;
    logic [W-1:0] add_rhs;
    logic [W-1:0] sum;
    logic [W-1:0] diff_fwd;   // x - w*y, used only in forward mode

    assign dir = bf_dir_e'(dir_i);

    modq_sub #(.W(W), .Q(Q)) u_sub_inv (
        .x_i (y_i),
        .y_i (x_i),
        .d_o (diff_inv)
    );

    assign mul_rhs = (dir == BF_INV) ? diff_inv : y_i;

    modq_mul #(.W(W), .Q(Q)) u_mul (
        .x_i (w_i),
        .y_i (mul_rhs),
        .p_o (prod)
    );

    assign add_rhs = (dir == BF_INV) ? y_i : prod;

    modq_add #(.W(W), .Q(Q)) u_add (
        .x_i (x_i),
        .y_i (add_rhs),
        .s_o (sum)
    );

    modq_sub #(.W(W), .Q(Q)) u_sub_fwd (
        .x_i (x_i),
        .y_i (prod),
        .d_o (diff_fwd)
    );

    assign x_o = sum;
    assign y_o = (dir == BF_INV) ? prod : diff_fwd;

    // Output relations checked with plain integer arithmetic
    always_comb begin
        if (!$isunknown({x_i, y_i, w_i, dir_i}) &&
            ({1'b0, x_i} < QX) && ({1'b0, y_i} < QX) && ({1'b0, w_i} < QX)) begin
            a_r1_outputs_canonical: assert (({1'b0, x_o} < QX) && ({1'b0, y_o} < QX))
                else $error("butterfly output out of range");
            if (dir_i == 1'b0) begin
                a_r3_fwd_sum_of_outputs: assert (((int'(x_o) + int'(y_o)) % int'(Q)) ==
                                                 ((2 * int'(x_i)) % int'(Q)))
                    else $error("forward outputs do not sum to 2x");
            end else begin
                a_r4_inv_upper: assert (int'(x_o) == ((int'(x_i) + int'(y_i)) % int'(Q)))
                    else $error("inverse upper output wrong");
                if (w_i == W'(1)) begin
                    a_r5_inv_unit_twiddle: assert (int'(y_o) ==
                                                   ((int'(y_i) - int'(x_i) + int'(Q)) % int'(Q)))
                        else $error("inverse lower output wrong for unit twiddle");
                end
            end
        end
    end

endmodule

// File: tb/test_modq_butterfly.sv
module test_modq_butterfly;

    localparam int Q = 3329;

    logic        clk;
    logic        rst;
    logic [11:0] x_i, y_i, w_i;
    logic        dir_i;
    logic [11:0] x_o, y_o;

    int n_tests;
    int n_fail;
    int cycles;
    bit finished;

    // expected results, pushed at drive and popped at compare
    int exp_q[$];

    modq_butterfly i_modq_butterfly (
        .x_i   (x_i),
        .y_i   (y_i),
        .w_i   (w_i),
        .dir_i (dir_i),
        .x_o   (x_o),
        .y_o   (y_o)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    function automatic int ref_upper(int a, int b, int w, bit inv);
        int t;
        if (inv) return (a + b) % Q;
        t = (w * b) % Q;
        return (a + t) % Q;
    endfunction

    function automatic int ref_lower(int a, int b, int w, bit inv);
        int t;
        if (inv) return (w * ((b - a + Q) % Q)) % Q;
        t = (w * b) % Q;
        return (a - t + Q) % Q;
    endfunction

    task automatic check(string req, int got, int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // drive after a rising edge, compare at the following falling edge
    task automatic run_vec(int a, int b, int w, bit inv, string req_hi, string req_lo);
        int eh, el;
        @(posedge clk);
        #1;
        x_i = 12'(a); y_i = 12'(b); w_i = 12'(w); dir_i = inv;
        exp_q.push_back(ref_upper(a, b, w, inv));
        exp_q.push_back(ref_lower(a, b, w, inv));
        @(negedge clk);
        eh = exp_q.pop_front();
        el = exp_q.pop_front();
        check(req_hi, int'(x_o), eh);
        check(req_lo, int'(y_o), el);
    endtask

    function automatic void finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected fewer than 100000", cycles);
            finish_run();
        end
    end

    initial begin
        n_tests = 0; n_fail = 0; cycles = 0; finished = 1'b0;
        rst = 1'b1;
        x_i = '0; y_i = '0; w_i = 12'd17; dir_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: zero coefficients held during reset give zero outputs
        check("R10 reset fwd upper", int'(x_o), 0);
        check("R10 reset fwd lower", int'(y_o), 0);
        rst = 1'b0;

        run_vec(0, 0, 1234, 1'b1, "R10 inv zero upper", "R10 inv zero lower");
        // R8: unit twiddle, forward, top of range
        run_vec(Q-1, Q-1, 1, 1'b0, "R8 fwd unit upper", "R8 fwd unit lower");
        run_vec(100, 40, 1, 1'b0, "R8 fwd unit upper 2", "R8 fwd unit lower 2");
        // R7: borrow in inverse difference
        run_vec(1, 0, 1, 1'b1, "R4 inv upper", "R7 inv borrow");
        // R6: sum wrap in inverse mode
        run_vec(Q-1, 1, 5, 1'b1, "R6 inv wrap", "R5 inv lower");
        // R11: (q-1)*(q-1) = 1
        run_vec(0, Q-1, Q-1, 1'b0, "R11 fwd upper", "R11 fwd lower");
        // wrap and borrow together in forward mode
        run_vec(1, Q-1, 1, 1'b0, "R2 R6 wrap upper", "R3 R7 borrow lower");
        run_vec(Q-1, Q-1, Q-1, 1'b1, "R4 inv top upper", "R5 inv top lower");
        run_vec(Q-1, 0, Q-1, 1'b0, "R2 fwd upper", "R3 fwd lower");

        // R9: output follows input with no clock edge in between
        @(negedge clk);
        x_i = 12'd7; y_i = 12'd9; w_i = 12'd3; dir_i = 1'b1;
        #1;
        check("R9 comb upper", int'(x_o), 16);
        check("R9 comb lower", int'(y_o), 6);
        dir_i = 1'b0;
        #1;
        check("R9 comb mode upper", int'(x_o), 34);
        check("R9 comb mode lower", int'(y_o), (7 - 27 + Q) % Q);

        // R1..R5: random vectors in both modes
        for (int k = 0; k < 3000; k++) begin
            int a, b, w;
            bit inv;
            a = int'($urandom_range(Q-1, 0));
            b = int'($urandom_range(Q-1, 0));
            w = int'($urandom_range(Q-1, 0));
            inv = 1'($urandom_range(1, 0));
            if (inv) run_vec(a, b, w, inv, "R1 R4 random upper", "R1 R5 random lower");
            else     run_vec(a, b, w, inv, "R1 R2 random upper", "R1 R3 random lower");
        end

        finish_run();
    end

endmodule